// File: doc/BRIEF.md
# Card Column Timing Generator

This block times the columns of a punched card as it passes a row of photocells. The feed wheel delivers a tooth pulse for every column pitch, but those pulses are not aligned with the card itself. After a pick, the block counts master-clock cycles from the most recent tooth edge to the first moment any photocell goes dark, which is the card's leading edge. It then replays that same delay after every later tooth edge. When the delay runs out, it passes exactly one phase-C high and then one phase-D high from the four-phase clock. These gated strobes sample and then clear the photocell latches elsewhere.

The phase-D strobe advances a column counter. The counter exposes four decoded positions: left edge, one past the last data column, the trailing-edge check point and the end of card. An impulse marker accompanies the phase-C strobe for each of the 80 data columns. The end-of-card position stops the strobes. A pick request or a synchronous reset returns the block to waiting for the next leading edge.

Top module: `card_col_timer`

## Requirements
- R1: After `rst` the block is idle: `reading`=0, `col`=0, and `st_c`, `st_d` and `im` are low. While idle, tooth edges produce no strobes.
- R2: A rising edge on `dark` while idle sets `reading`=1 on the next cycle, with `col`=0 and `at_col0`=1.
- R3: The delay n is the number of clock edges from the edge that samples a tooth rise to the edge that samples the dark rise. It saturates at 4095 and is captured again at every leading edge.
- R4: While reading, a tooth rise sampled at edge E opens the gate for the cycle that follows edge E+n. `st_c` then copies `ph_c` in the first cycle at or after that point where `ph_c` is high. `st_d` copies `ph_d` in the next cycle where `ph_d` is high. The gate then stays closed until the next tooth rise.
- R5: Each `st_d` pulse adds one to `col`. `at_col81` is high exactly when `col`=81, and `at_col84` is high exactly when `col`=84.
- R6: `im` copies `st_c` only for columns 1 to 80, which gives exactly 80 markers per card. The marker enable is set by the strobe at column 0 and cleared when `col` reaches 81.
- R7: When `col` reaches 86, `at_eoc` goes high, `reading` drops and no further strobes occur. While a card is being read, further `dark` edges have no effect.
- R8: A second card uses the delay measured at its own leading edge, not the delay from the previous card.
- R9: A `pick` pulse returns the block to idle: `reading`=0, `col`=0, and later tooth edges produce no strobes until a new leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| pick | input | 1 | Pick request; aborts and re-arms |
| tooth | input | 1 | Feed-wheel tooth sensor level |
| dark | input | 1 | High when any photocell is dark |
| ph_c | input | 1 | Clock phase C |
| ph_d | input | 1 | Clock phase D |
| st_c | output | 1 | Gated phase-C column strobe |
| st_d | output | 1 | Gated phase-D column strobe |
| im | output | 1 | Impulse marker for a data column |
| reading | output | 1 | A card is being timed |
| col | output | 7 | Column counter |
| at_col0 | output | 1 | Left-edge position |
| at_col81 | output | 1 | One past the last data column |
| at_col84 | output | 1 | Trailing-edge check position |
| at_eoc | output | 1 | End-of-card position |

## Verification
A wrong captured delay shows up at the very first strobe after the leading edge: `st_c` lands on a different phase-C slot than the one computed from the tooth-to-edge spacing. A mistake in saturation appears the same way on a card with a long gap. A counter or marker-enable fault stays hidden until the decoded positions. It becomes visible as a wrong `col` after the strobe pair, a marker count other than 80 when column 81 is reached, or strobes that continue past the end of card. A pick that fails to clear state appears within two cycles on `reading` and `col`.

// File: rtl/card_col_timer.sv
module card_col_timer #(
  parameter int DLY_W     = 12,
  parameter int COL_W     = 7,
  parameter int DATA_COLS = 80,
  parameter int EOC_COL   = 86
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pick,
  input  logic             tooth,
  input  logic             dark,
  input  logic             ph_c,
  input  logic             ph_d,
  output logic             st_c,
  output logic             st_d,
  output logic             im,
  output logic             reading,
  output logic [COL_W-1:0] col,
  output logic             at_col0,
  output logic             at_col81,
  output logic             at_col84,
  output logic             at_eoc
);
  localparam int STOP_I  = DATA_COLS + 1;
  localparam int TRAIL_I = DATA_COLS + 4;
  localparam logic [COL_W-1:0] K_STOP  = STOP_I[COL_W-1:0];
  localparam logic [COL_W-1:0] K_TRAIL = TRAIL_I[COL_W-1:0];
  localparam logic [COL_W-1:0] K_EOC   = EOC_COL[COL_W-1:0];
  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};
  localparam logic [DLY_W-1:0] ONE     = DLY_W'(1);

  typedef enum logic [1:0] {G_OFF, G_C, G_D} gate_t;

  gate_t            gate;
  logic             tooth_q, dark_q, tmr_on, im_en;
  logic [DLY_W-1:0] meas, dly, tmr;

  wire tooth_rise = tooth & ~tooth_q;
  wire dark_rise  = dark & ~dark_q;
  wire expire     = tooth_rise ? (dly == '0) : (tmr_on && tmr <= ONE);

  assign st_c     = reading & (gate == G_C) & ph_c;
  assign st_d     = reading & (gate == G_D) & ph_d;
  assign im       = st_c & im_en;
  assign at_col0  = reading & (col == '0);
  assign at_col81 = (col == K_STOP);
  assign at_col84 = (col == K_TRAIL);
  assign at_eoc   = (col == K_EOC);

  always_ff @(posedge clk) begin
    if (rst) begin
      tooth_q <= 1'b0;
      dark_q  <= 1'b0;
      meas    <= '0;
      dly     <= '0;
      tmr     <= '0;
      tmr_on  <= 1'b0;
      gate    <= G_OFF;
      reading <= 1'b0;
      col     <= '0;
      im_en   <= 1'b0;
    end else begin
      tooth_q <= tooth;
      dark_q  <= dark;
      if (tooth_rise)
        meas <= ONE;
      else if (meas != DLY_MAX)
        meas <= meas + ONE;

      if (pick) begin
        reading <= 1'b0;
        col     <= '0;
        gate    <= G_OFF;
        tmr_on  <= 1'b0;
        im_en   <= 1'b0;
      end else if (!reading) begin
        if (dark_rise) begin
          reading <= 1'b1;
          col     <= '0;
          dly     <= meas;
          gate    <= G_OFF;
          tmr_on  <= 1'b0;
          im_en   <= 1'b0;
        end
      end else if (col == K_EOC) begin
        reading <= 1'b0;
        gate    <= G_OFF;
        tmr_on  <= 1'b0;
      end else begin
        if (tooth_rise) begin
          tmr    <= dly;
          tmr_on <= (dly != '0);
        end else if (tmr_on) begin
          if (tmr <= ONE) tmr_on <= 1'b0;
          else            tmr    <= tmr - ONE;
        end

        if (expire)
          gate <= G_C;
        else begin
          case (gate)
            G_C:     if (ph_c) gate <= G_D;
            G_D:     if (ph_d) gate <= G_OFF;
            default: gate <= G_OFF;
          endcase
        end

        if (st_d) col <= col + 1'b1;

        if (st_d && col == '0)  im_en <= 1'b1;
        else if (col == K_STOP) im_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/card_col_timer_chk.sv
module card_col_timer_chk #(
  parameter int COL_W     = 7,
  parameter int DATA_COLS = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             pick,
  input logic             st_c,
  input logic             st_d,
  input logic             im,
  input logic             reading,
  input logic             at_eoc,
  input logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] K_LAST = DATA_COLS[COL_W-1:0];

  // R4: a phase-D strobe always follows a phase-C strobe directly
  a_r4_d_after_c: assert property (@(posedge clk) disable iff (rst)
    st_d |-> $past(st_c));

  // R5: each phase-D strobe moves the counter up by exactly one
  a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
    ($past(st_d) && $past(reading) && !$past(pick)) |-> (col == $past(col) + 1'b1));

  // R6: markers only on data columns
  a_r6_im_data_cols: assert property (@(posedge clk) disable iff (rst)
    im |-> (col != '0 && col <= K_LAST));

  // R7: no strobes while idle; end of card drops reading
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !reading |-> (!st_c && !st_d));

  a_r7_eoc_stops: assert property (@(posedge clk) disable iff (rst)
    (at_eoc && reading && !pick) |=> !reading);

  // R9: pick returns to idle
  a_r9_pick_clears: assert property (@(posedge clk) disable iff (rst)
    pick |=> (!reading && col == '0));
endmodule

bind card_col_timer card_col_timer_chk #(.COL_W(COL_W), .DATA_COLS(DATA_COLS)) u_chk (
  .clk(clk), .rst(rst), .pick(pick), .st_c(st_c), .st_d(st_d), .im(im),
  .reading(reading), .at_eoc(at_eoc), .col(col)
);

// File: tb/card_col_timer_bench.sv
`timescale 1ns/1ps
module card_col_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, pick = 1'b0, tooth = 1'b0, dark = 1'b0, ph_c = 1'b0, ph_d = 1'b0;
  logic st_c, st_d, im, reading, at_col0, at_col81, at_col84, at_eoc;
  logic [6:0] col;

  int cyc = 0, checks = 0, errors = 0;
  int n_c = 0, n_d = 0, n_im = 0, last_c = -1, last_d = -1;
  bit done = 1'b0;
  localparam int P = 24;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  card_col_timer u_card_col_timer (
    .clk(clk), .rst(rst), .pick(pick), .tooth(tooth), .dark(dark),
    .ph_c(ph_c), .ph_d(ph_d), .st_c(st_c), .st_d(st_d), .im(im),
    .reading(reading), .col(col), .at_col0(at_col0), .at_col81(at_col81),
    .at_col84(at_col84), .at_eoc(at_eoc)
  );

  initial forever begin
    @(posedge clk); #1;
    ph_c = (cyc % 4 == 2);
    ph_d = (cyc % 4 == 3);
  end

  always @(negedge clk) begin
    if (st_c) begin n_c++; last_c = cyc; end
    if (st_d) begin n_d++; last_d = cyc; end
    if (im) n_im++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int k);
    while (cyc < k) begin @(posedge clk); #1; end
  endtask

  task automatic tooth_at(input int k);
    go(k); tooth = 1'b1;
    go(k + 2); tooth = 1'b0;
  endtask

  task automatic pulse_pick();
    go(cyc + 1); pick = 1'b1;
    go(cyc + 1); pick = 1'b0;
  endtask

  function automatic int exp_c(input int g);
    int j = g;
    while (j % 4 != 2) j++;
    return j;
  endfunction

  task automatic start_card(input int n, output int k0);
    dark = 1'b0;
    k0 = cyc + 4;
    tooth_at(k0);
    go(k0 + n); dark = 1'b1;
    go(k0 + n + 2);
    chk(reading == 1'b1, "R2 reading after leading edge", reading, 1);
    chk(col == 7'd0 && at_col0, "R2 col0 decode", col, 0);
  endtask

  task automatic t_reset();
    int c0, k;
    go(cyc + 1);
    chk(reading == 1'b0, "R1 reading after reset", reading, 0);
    chk(col == 7'd0 && !st_c && !st_d && !im, "R1 idle outputs", col, 0);
    c0 = n_c;
    k = cyc + 2;
    for (int i = 0; i < 3; i++) tooth_at(k + P * i);
    go(k + 3 * P);
    chk(n_c == c0, "R1 teeth without card give no strobe", n_c - c0, 0);
  endtask

  task automatic t_card(input int n);
    int k0, k, c0, d0, im0, e;
    start_card(n, k0);
    c0 = n_c; d0 = n_d; im0 = n_im;
    for (int i = 0; i < 86; i++) begin
      k = k0 + P * (i + 1);
      tooth_at(k);
      if (i == 10) begin
        go(k + 3); dark = 1'b0;
        go(k + 5); dark = 1'b1;
      end
      go(k + P - 2);
      if (i == 0) begin
        e = exp_c(k + 1 + n);
        chk(last_c == e, "R4 R8 first phase-C strobe cycle", last_c, e);
        chk(last_d == e + 1, "R4 phase-D strobe cycle", last_d, e + 1);
        chk(n_im == im0, "R6 no marker at column 0", n_im - im0, 0);
        chk(col == 7'd1, "R5 col after first strobe", col, 1);
      end
      if (i == 10) chk(col == 7'd11, "R7 mid-card dark edge ignored", col, 11);
      if (i == 80) begin
        chk(col == 7'd81 && at_col81 && !at_col84, "R5 column 81 decode", col, 81);
        chk(n_im - im0 == 80, "R6 markers at column 81", n_im - im0, 80);
      end
      if (i == 83) chk(col == 7'd84 && at_col84 && !at_col81, "R5 column 84 decode", col, 84);
      if (i == 85) chk(col == 7'd86 && at_eoc && !reading, "R7 end of card", col, 86);
    end
    chk(n_c - c0 == 86 && n_d - d0 == 86, "R5 strobe pairs per card", n_c - c0, 86);
    chk(n_im - im0 == 80, "R6 markers per card", n_im - im0, 80);
    c0 = n_c;
    k = k0 + P * 87;
    tooth_at(k);
    go(k + P);
    chk(n_c == c0, "R7 no strobe after end of card", n_c - c0, 0);
    dark = 1'b0;
  endtask

  task automatic t_saturate();
    int k, k2, e;
    pulse_pick();
    dark = 1'b0;
    k = cyc + 4;
    tooth_at(k);
    go(k + 5000); dark = 1'b1;
    go(k + 5002);
    chk(reading == 1'b1, "R2 leading edge after long gap", reading, 1);
    k2 = k + 5010;
    tooth_at(k2);
    e = exp_c(k2 + 1 + 4095);
    go(e + 4);
    chk(last_c == e, "R3 saturated delay", last_c, e);
    pulse_pick();
    go(cyc + 2);
    chk(!reading && col == 7'd0, "R9 pick clears state", col, 0);
    dark = 1'b0;
  endtask

  task automatic t_pick();
    int k0, k, c0;
    start_card(5, k0);
    for (int i = 0; i < 3; i++) tooth_at(k0 + P * (i + 1));
    go(k0 + 4 * P - 2);
    chk(col == 7'd3, "R5 col before pick", col, 3);
    pulse_pick();
    go(cyc + 2);
    chk(!reading && col == 7'd0, "R9 pick mid-card", col, 0);
    c0 = n_c;
    k = cyc + 2;
    tooth_at(k);
    go(k + P);
    chk(n_c == c0, "R9 no strobe after pick", n_c - c0, 0);
    dark = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_card(3);
    t_card(9);
    t_saturate();
    t_pick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule